// File: doc/BRIEF.md
# Stack Pointer and Data Exception Unit

This unit keeps the stack pointer of a 16-bit processor whose data memory holds 2^20 words, addressed by word. Each cycle it decodes the stack and data strobes of the instruction in the memory stage. It then supplies the word address and write enable for the memory port, and it moves the stack pointer by one word for single-word operations or by two words for return-address frames.

The same cycle it checks for two faults. The first is a pop-type operation on a stack that holds too few words. The second is a load or store whose effective address lies above the top of the legal data range. When either fault is found, the unit raises an exception flag, reports the cause and the instruction-memory slot that holds the handler address, and latches the faulting instruction's address into an exception program counter. A faulting cycle leaves the stack pointer unchanged and writes nothing to memory. Fetching the handler address from its slot is left to the fetch logic.

Top module: `stack_exc_unit`

## Requirements
- R1: Synchronous active-high reset sets `sp_out` to 0xFFFFF and `epc` to 0.
- R2: A push (`op_push`) drives `mem_addr` = SP with `mem_we` = 1, and SP becomes SP−1 after the clock edge.
- R3: A pop (`op_pop`) drives `mem_addr` = SP+1 with `mem_we` = 0, and SP becomes SP+1.
- R4: A call (`op_call`) or interrupt entry (`op_int`) drives `mem_addr` = SP with `mem_we` = 1, and SP becomes SP−2.
- R5: A return (`op_ret`) or interrupt return (`op_rti`) drives `mem_addr` = SP+2 with `mem_we` = 0, and SP becomes SP+2.
- R6: A pop-type operation whose SP plus pop size (1 for pop, 2 for ret/rti) exceeds 0xFFFFF raises `exc_valid`, with `exc_cause` = 2'b01 (empty stack) and `vec_slot` = 3'd2.
- R7: With no stack strobe active, a load or store drives `mem_addr` = `eff_addr`, and a store drives `mem_we` = 1. A load or store with `eff_addr` > 0x0FF00 raises `exc_valid`, with `exc_cause` = 2'b10 (bad address) and `vec_slot` = 3'd4. The address 0x0FF00 itself is legal. Without an exception, `exc_cause` = 2'b00 and `vec_slot` = 0.
- R8: When an empty-stack fault and a bad-address fault occur in the same cycle, the cause is empty stack (2'b01, slot 2).
- R9: In any cycle with `exc_valid` = 1, `mem_we` is 0 and SP keeps its value.
- R10: In a cycle with `exc_valid`, `epc` loads `instr_addr` and shows it after the clock edge. In other cycles `epc` holds its value.
- R11: A stack strobe owns the memory port over a load or store in the same cycle. Among simultaneous stack strobes, the order of precedence is call, int, push, ret, rti, pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_push | input | 1 | Single-word push strobe |
| op_pop | input | 1 | Single-word pop strobe |
| op_call | input | 1 | Call strobe (two-word frame) |
| op_ret | input | 1 | Return strobe (two-word frame) |
| op_int | input | 1 | Interrupt entry strobe (two-word frame) |
| op_rti | input | 1 | Interrupt return strobe (two-word frame) |
| op_load | input | 1 | Data load strobe |
| op_store | input | 1 | Data store strobe |
| eff_addr | input | 20 | Effective address of the load or store |
| instr_addr | input | 20 | Address of the instruction now in this stage |
| mem_addr | output | 20 | Word address for the data memory port |
| mem_we | output | 1 | Data memory write enable |
| sp_out | output | 20 | Current stack pointer |
| exc_valid | output | 1 | Exception raised this cycle |
| exc_cause | output | 2 | 00 none, 01 empty stack, 10 bad address |
| vec_slot | output | 3 | Instruction-memory word that starts the handler address (2 or 4, else 0) |
| epc | output | 20 | Exception program counter |

## Verification
The two fault detectors can fire in the same cycle when a pop-type strobe on an empty stack comes together with a load whose effective address is above 0x0FF00. The bench provokes this with a pop at SP 0xFFFFF paired with a load of 0xFFFFF. It expects cause 01 and slot 2, no write, an unchanged SP, and the faulting instruction address in `epc`. It also pairs a push with an out-of-range load to confirm that a bad-address fault alone still blocks both the stack write and the SP step.

// File: rtl/sp_exc_pkg.sv
package sp_exc_pkg;

    localparam int ADDR_W = 20;
    localparam int SIZE_W = 2;
    localparam int SLOT_W = 3;

    localparam logic [ADDR_W-1:0] SP_RESET   = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] DATA_LIMIT = ADDR_W'(20'h0FF00);

    localparam logic [SLOT_W-1:0] SLOT_NONE    = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_EMPTY   = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_BADADDR = 3'd4;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_EMPTY   = 2'b01,
        CAUSE_BADADDR = 2'b10
    } exc_cause_e;

    // Decoded stack operation carried through the datapath
    typedef struct packed {
        logic              active;  // some stack strobe is set
        logic              write;   // frame is stored to memory
        logic              grow;    // SP moves up (pop-type)
        logic [SIZE_W-1:0] size;    // words moved
    } stack_op_t;

    localparam stack_op_t STACK_IDLE = '{active: 1'b0, write: 1'b0, grow: 1'b0, size: '0};

    function automatic stack_op_t mk_op(input logic wr, input logic up, input logic [SIZE_W-1:0] n);
        stack_op_t o;
        o.active = 1'b1;
        o.write  = wr;
        o.grow   = up;
        o.size   = n;
        return o;
    endfunction

endpackage

// File: rtl/sp_op_decode.sv
module sp_op_decode
    import sp_exc_pkg::*;
(
    input  logic      push_i,
    input  logic      pop_i,
    input  logic      call_i,
    input  logic      ret_i,
    input  logic      int_i,
    input  logic      rti_i,
    output stack_op_t op_o
);
    always_comb begin
        if (call_i)      op_o = mk_op(1'b1, 1'b0, 2'd2);
        else if (int_i)  op_o = mk_op(1'b1, 1'b0, 2'd2);
        else if (push_i) op_o = mk_op(1'b1, 1'b0, 2'd1);
        else if (ret_i)  op_o = mk_op(1'b0, 1'b1, 2'd2);
        else if (rti_i)  op_o = mk_op(1'b0, 1'b1, 2'd2);
        else if (pop_i)  op_o = mk_op(1'b0, 1'b1, 2'd1);
        else             op_o = STACK_IDLE;
    end
endmodule

// File: rtl/sp_addr_calc.sv
module sp_addr_calc
    import sp_exc_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] sp_i,
    input  stack_op_t     op_i,
    output logic [AW-1:0] stack_addr_o,
    output logic [AW-1:0] sp_next_o,
    output logic          empty_o
);
    localparam logic [AW:0] TOP_WIDE = {1'b0, {AW{1'b1}}};

    logic [AW:0]   up_sum;
    logic [AW-1:0] down_diff;

    always_comb begin
        up_sum    = {1'b0, sp_i} + (AW+1)'(op_i.size);
        down_diff = sp_i - AW'(op_i.size);
        empty_o   = op_i.active && op_i.grow && (up_sum > TOP_WIDE);
        if (op_i.grow) begin
            stack_addr_o = up_sum[AW-1:0];
            sp_next_o    = up_sum[AW-1:0];
        end else begin
            stack_addr_o = sp_i;
            sp_next_o    = down_diff;
        end
    end
endmodule

// File: rtl/sp_exc_arbiter.sv
module sp_exc_arbiter
    import sp_exc_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              empty_i,
    input  logic              data_access_i,
    input  logic [AW-1:0]     eff_addr_i,
    output logic              valid_o,
    output exc_cause_e        cause_o,
    output logic [SLOT_W-1:0] slot_o
);
    logic bad_addr;

    always_comb begin
        bad_addr = data_access_i && (eff_addr_i > AW'(DATA_LIMIT));
        if (empty_i) begin
            cause_o = CAUSE_EMPTY;
            slot_o  = SLOT_EMPTY;
        end else if (bad_addr) begin
            cause_o = CAUSE_BADADDR;
            slot_o  = SLOT_BADADDR;
        end else begin
            cause_o = CAUSE_NONE;
            slot_o  = SLOT_NONE;
        end
        valid_o = empty_i || bad_addr;
    end
endmodule

// File: rtl/stack_exc_unit.sv
module stack_exc_unit
    import sp_exc_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_push,
    input  logic          op_pop,
    input  logic          op_call,
    input  logic          op_ret,
    input  logic          op_int,
    input  logic          op_rti,
    input  logic          op_load,
    input  logic          op_store,
    input  logic [AW-1:0] eff_addr,
    input  logic [AW-1:0] instr_addr,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [AW-1:0] sp_out,
    output logic          exc_valid,
    output logic [1:0]    exc_cause,
    output logic [2:0]    vec_slot,
    output logic [AW-1:0] epc
);
    stack_op_t     op;
    logic [AW-1:0] stack_addr;
    logic [AW-1:0] sp_next;
    logic          empty;
    exc_cause_e    cause;
    logic [AW-1:0] sp_q;
    logic [AW-1:0] epc_q;

    sp_op_decode u_dec (
        .push_i (op_push),
        .pop_i  (op_pop),
        .call_i (op_call),
        .ret_i  (op_ret),
        .int_i  (op_int),
        .rti_i  (op_rti),
        .op_o   (op)
    );

    sp_addr_calc #(.AW(AW)) u_calc (
        .sp_i         (sp_q),
        .op_i         (op),
        .stack_addr_o (stack_addr),
        .sp_next_o    (sp_next),
        .empty_o      (empty)
    );

    sp_exc_arbiter #(.AW(AW)) u_arb (
        .empty_i       (empty),
        .data_access_i (op_load | op_store),
        .eff_addr_i    (eff_addr),
        .valid_o       (exc_valid),
        .cause_o       (cause),
        .slot_o        (vec_slot)
    );

    // Stack operations own the memory port
    always_comb begin
        if (op.active) begin
            mem_addr = stack_addr;
            mem_we   = op.write && !exc_valid;
        end else begin
            mem_addr = eff_addr;
            mem_we   = op_store && !exc_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q  <= AW'(SP_RESET);
            epc_q <= '0;
        end else begin
            if (op.active && !exc_valid) sp_q <= sp_next;
            if (exc_valid)               epc_q <= instr_addr;
        end
    end

    assign sp_out    = sp_q;
    assign epc       = epc_q;
    assign exc_cause = cause;
endmodule

// File: rtl/stack_exc_unit_chk.sv
module stack_exc_unit_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          op_push,
    input logic          op_pop,
    input logic          op_call,
    input logic          op_ret,
    input logic          op_int,
    input logic          op_rti,
    input logic          op_load,
    input logic [AW-1:0] instr_addr,
    input logic [AW-1:0] eff_addr,
    input logic          mem_we,
    input logic [AW-1:0] sp_out,
    input logic          exc_valid,
    input logic [1:0]    exc_cause,
    input logic [2:0]    vec_slot,
    input logic [AW-1:0] epc
);
    logic only_push;
    assign only_push = op_push && !op_call && !op_int;

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        (only_push && !exc_valid) |=> (sp_out == $past(sp_out) - 1'b1)) // R2
        else $error("push did not step SP down by one");

    AST_NO_WRITE_ON_EXC: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> !mem_we) // R9
        else $error("write enable during exception");

    AST_SP_FROZEN_ON_EXC: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> $stable(sp_out)) // R9
        else $error("SP moved on exception");

    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> (epc == $past(instr_addr))) // R10
        else $error("EPC missed faulting address");

    AST_EPC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |=> $stable(epc)) // R10
        else $error("EPC changed without exception");

    AST_EMPTY_WINS: assert property (@(posedge clk) disable iff (rst)
        (op_pop && !op_call && !op_int && !op_push && !op_ret && !op_rti
         && (sp_out == {AW{1'b1}}) && op_load && (eff_addr > AW'(20'h0FF00)))
        |-> (exc_cause == 2'b01)) // R8
        else $error("empty stack did not win priority");

    AST_SLOT_MATCH: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> ((exc_cause == 2'b01 && vec_slot == 3'd2) ||
                       (exc_cause == 2'b10 && vec_slot == 3'd4))) // R6
        else $error("slot does not match cause");

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |-> (exc_cause == 2'b00 && vec_slot == 3'd0)) // R7
        else $error("cause reported without exception");
endmodule

bind stack_exc_unit stack_exc_unit_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_push    (op_push),
    .op_pop     (op_pop),
    .op_call    (op_call),
    .op_ret     (op_ret),
    .op_int     (op_int),
    .op_rti     (op_rti),
    .op_load    (op_load),
    .instr_addr (instr_addr),
    .eff_addr   (eff_addr),
    .mem_we     (mem_we),
    .sp_out     (sp_out),
    .exc_valid  (exc_valid),
    .exc_cause  (exc_cause),
    .vec_slot   (vec_slot),
    .epc        (epc)
);

// File: tb/stack_exc_unit_test.sv
`timescale 1ns/1ps
module stack_exc_unit_test;

    localparam int AW = 20;
    localparam int NV = 16;
    // strobes[7:0] = push,pop,call,ret,int,rti,load,store
    // vector = {strobes, eff_addr, exp_addr, exp_we, exp_cause, exp_sp_after}
    localparam int VW = 8 + AW + AW + 1 + 2 + AW;

    localparam logic [VW-1:0] VEC [NV] = '{
        {8'b0100_0000, 20'h00000, 20'h00000, 1'b0, 2'b01, 20'hFFFFF}, // R6 pop on empty
        {8'b1000_0000, 20'h00000, 20'hFFFFF, 1'b1, 2'b00, 20'hFFFFE}, // R2 push
        {8'b0010_0000, 20'h00000, 20'hFFFFE, 1'b1, 2'b00, 20'hFFFFC}, // R4 call
        {8'b0000_1000, 20'h00000, 20'hFFFFC, 1'b1, 2'b00, 20'hFFFFA}, // R4 int
        {8'b0000_0100, 20'h00000, 20'hFFFFC, 1'b0, 2'b00, 20'hFFFFC}, // R5 rti
        {8'b0001_0000, 20'h00000, 20'hFFFFE, 1'b0, 2'b00, 20'hFFFFE}, // R5 ret
        {8'b0001_0000, 20'h00000, 20'h00000, 1'b0, 2'b01, 20'hFFFFE}, // R6 ret short
        {8'b0100_0000, 20'h00000, 20'hFFFFF, 1'b0, 2'b00, 20'hFFFFF}, // R3 pop
        {8'b0000_0001, 20'h0FF00, 20'h0FF00, 1'b1, 2'b00, 20'hFFFFF}, // R7 limit ok
        {8'b0000_0010, 20'h0FF01, 20'h00000, 1'b0, 2'b10, 20'hFFFFF}, // R7 load bad
        {8'b0000_0001, 20'h12345, 20'h00000, 1'b0, 2'b10, 20'hFFFFF}, // R7 store bad
        {8'b0000_0010, 20'h00010, 20'h00010, 1'b0, 2'b00, 20'hFFFFF}, // R7 load ok
        {8'b0100_0010, 20'hFFFFF, 20'h00000, 1'b0, 2'b01, 20'hFFFFF}, // R8 both
        {8'b1000_0001, 20'h00020, 20'hFFFFF, 1'b1, 2'b00, 20'hFFFFE}, // R11 push owns
        {8'b1000_0010, 20'h1FFFF, 20'h00000, 1'b0, 2'b10, 20'hFFFFE}, // R9 push blocked
        {8'b1100_0000, 20'h00000, 20'hFFFFE, 1'b1, 2'b00, 20'hFFFFD}  // R11 push over pop
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_push = 0, op_pop = 0, op_call = 0, op_ret = 0;
    logic          op_int = 0, op_rti = 0, op_load = 0, op_store = 0;
    logic [AW-1:0] eff_addr = '0;
    logic [AW-1:0] instr_addr = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [AW-1:0] sp_out;
    logic          exc_valid;
    logic [1:0]    exc_cause;
    logic [2:0]    vec_slot;
    logic [AW-1:0] epc;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    stack_exc_unit uut (
        .clk(clk), .rst(rst),
        .op_push(op_push), .op_pop(op_pop), .op_call(op_call), .op_ret(op_ret),
        .op_int(op_int), .op_rti(op_rti), .op_load(op_load), .op_store(op_store),
        .eff_addr(eff_addr), .instr_addr(instr_addr),
        .mem_addr(mem_addr), .mem_we(mem_we), .sp_out(sp_out),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .vec_slot(vec_slot), .epc(epc)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] s, input logic [AW-1:0] ea, input logic [AW-1:0] ia);
        {op_push, op_pop, op_call, op_ret, op_int, op_rti, op_load, op_store} = s;
        eff_addr   = ea;
        instr_addr = ia;
    endtask

    initial begin
        logic [AW-1:0] exp_epc;
        exp_epc = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", "sp after reset", 32'(sp_out), 32'hFFFFF);
        check("R1", "epc after reset", 32'(epc), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [7:0]    s;
            logic [AW-1:0] ea, xa, xsp;
            logic          xwe;
            logic [1:0]    xc;
            logic [2:0]    xslot;
            string         tag;
            {s, ea, xa, xwe, xc, xsp} = VEC[i];
            xslot = (xc == 2'b01) ? 3'd2 : (xc == 2'b10) ? 3'd4 : 3'd0;
            tag = $sformatf("R%0d", (xc == 2'b01) ? 6 : (xc == 2'b10) ? 7 : 2);
            drive(s, ea, AW'(32'h100 + i));
            #2;
            check(tag, $sformatf("v%0d exc_valid", i), 32'(exc_valid), 32'(xc != 2'b00));
            check(tag, $sformatf("v%0d cause", i), 32'(exc_cause), 32'(xc));
            check(tag, $sformatf("v%0d slot", i), 32'(vec_slot), 32'(xslot));
            check("R9", $sformatf("v%0d mem_we", i), 32'(mem_we), 32'(xwe));
            if (xc == 2'b00)
                check("R11", $sformatf("v%0d mem_addr", i), 32'(mem_addr), 32'(xa));
            if (xc != 2'b00) exp_epc = AW'(32'h100 + i);
            @(posedge clk);
            #1;
            check("R9", $sformatf("v%0d sp", i), 32'(sp_out), 32'(xsp));
            check("R10", $sformatf("v%0d epc", i), 32'(epc), 32'(exp_epc));
            @(negedge clk);
        end

        // R1: reset in mid-run restores the initial state
        drive(8'h0, '0, '0);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1", "sp after second reset", 32'(sp_out), 32'hFFFFF);
        check("R1", "epc after second reset", 32'(epc), 32'h0);

        // R5: ret from SP 0xFFFFD is legal (0xFFFFF not past the top)
        @(negedge clk);
        drive(8'b1000_0000, '0, 20'h00200);
        @(negedge clk);
        drive(8'b1000_0000, '0, 20'h00201);
        @(negedge clk);
        drive(8'b0000_0100, '0, 20'h00202);
        #2;
        check("R5", "rti at FFFFD no exception", 32'(exc_valid), 32'h0);
        check("R5", "rti address", 32'(mem_addr), 32'hFFFFF);
        @(posedge clk);
        #1;
        check("R5", "sp after rti", 32'(sp_out), 32'hFFFFF);
        @(negedge clk);
        drive(8'h0, '0, '0);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule